// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers twelve interrupt sources for a small processor core and reduces them to one vectored request. Each source has a fixed rank and a fixed handler address. The block latches edge events, applies a per-source enable mask, a global service switch and a one-cycle mask blackout, and then offers the highest-ranked surviving source to the core. The offer uses a valid/ready pair. `irq_valid_o` and `irq_vector_o` are not held stable while `irq_ready_i` is low: a request can be withdrawn, or replaced by a higher-ranked one, in any cycle. A transfer takes place only in a cycle in which both are high.

A transfer counts as the acknowledge. It clears that source's edge latch and makes the source the active level. The previous active level is saved on a bounded status stack. A return strobe restores the saved level. Nesting can be switched on, so that only strictly higher-ranked sources pre-empt the routine in service. With nesting off, sources are serviced one at a time.

Source ranks, highest first, with their vectors. Rank 0 is a reset request (0x0000, level). Rank 1 is power-down (0x002C, edge, ignores the mask). Rank 2 is external line 2 (0x0004). Ranks 3 and 4 are level lines 1 and 0 (0x0008, 0x000C). Ranks 5 and 6 are serial port 0 transmit and receive (0x0010, 0x0014). Rank 7 is the forceable edge line (0x0018). Rank 8 is block DMA (0x001C). Rank 9 is serial port 1 transmit or external line 1 (0x0020). Rank 10 is serial port 1 receive or external line 0 (0x0024). Rank 11 is the timer (0x0028). Serial, DMA and timer inputs are rising-edge events.

Top module: `pvic_top`

## Requirements
- R1: The offered vector is the fixed address of the lowest-ranked-number eligible source. Rank 0 gives 0x0000 and rank 1 gives 0x002C. Any rank k from 2 to 11 gives 4*(k-1).
- R2: Bit j of the mask register (written with `mask_we_i`/`mask_wdata_i`) enables the source of rank j+2. A source whose bit is 0 is never offered. The mask resets to all zeros.
- R3: The power-down source (rank 1) is offered whatever the mask holds.
- R4: In the one cycle after a mask write, no source is offered except the reset request. Offers resume in the following cycle.
- R5: Control register bits: bit0, bit1 and bit2 make external lines 0, 1 and 2 edge-sensitive when 1 and level-sensitive when 0. Bit3 enables nesting. Bit4 routes external lines 0 and 1 in place of serial port 1 receive and transmit at ranks 10 and 9, and the serial inputs are then ignored. The register resets to 0.
- R6: The forceable line's latch is set by a rising edge of `edge_i` or by a force-register write with bit0 set. It is cleared by a write with bit1 set. When both bits are written, clear wins.
- R7: Level sources are not latched. When the line drops, its request disappears.
- R8: A transfer clears the edge latch of the transferred source only.
- R9: With nesting on, a request is offered only if its rank is strictly higher than the active level. With nesting off, a request is offered only when no level is active. The reset request is exempt in both cases.
- R10: `gie_clr_i` stops all offers except the reset request, power-down included. `gie_set_i` restores them. Clear wins when both are pulsed. Service is on after reset.
- R11: `rti_i` restores the previously active level and decrements the depth. It is ignored when the depth is 0 or in a transfer cycle.
- R12: The stack holds 12 entries. A transfer at depth 12 sets a sticky overflow flag, keeps the depth at 12 and overwrites no entry.
- R13: After reset, no request is offered, the depth is 0, overflow is 0 and the active level is 12 (idle). No transfer happens while `irq_ready_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| src_reset_i | input | 1 | Reset request, level, rank 0 |
| src_pwd_i | input | 1 | Power-down request, edge, rank 1 |
| ext_i | input | 3 | External lines 0..2, configurable edge/level |
| lvl_i | input | 2 | Level lines 0..1 |
| edge_i | input | 1 | Forceable edge line, rank 7 |
| s0_tx_i | input | 1 | Serial port 0 transmit event |
| s0_rx_i | input | 1 | Serial port 0 receive event |
| s1_tx_i | input | 1 | Serial port 1 transmit event |
| s1_rx_i | input | 1 | Serial port 1 receive event |
| dma_i | input | 1 | Block DMA event |
| timer_i | input | 1 | Timer event |
| mask_we_i | input | 1 | Mask register write strobe |
| mask_wdata_i | input | 10 | Mask value, bit j for rank j+2 |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 5 | Control value (see R5) |
| fc_we_i | input | 1 | Force/clear write strobe |
| fc_wdata_i | input | 2 | bit0 force, bit1 clear |
| gie_set_i | input | 1 | Global service enable pulse |
| gie_clr_i | input | 1 | Global service disable pulse |
| irq_valid_o | output | 1 | Request offered |
| irq_vector_o | output | VEC_W | Vector address of offered request |
| irq_ready_i | input | 1 | Core accepts the request |
| rti_i | input | 1 | Return-from-interrupt strobe |
| active_lvl_o | output | 4 | Rank in service, 12 when idle |
| depth_o | output | 4 | Stack depth |
| ovf_o | output | 1 | Sticky stack overflow |

## Verification
The priority function is tried with two sources pending together, a level line beside a latched timer event. This shows that the rank order, and not arrival order, picks the winner, and that a level request returns after a return strobe while an acknowledged edge does not. Masked and unmasked mixes, with and without power-down, separate mask gating from the nonmaskable path. A mask write with a source already pending shows the single blackout cycle. Rising sources above and below the active level, with nesting on, separate pre-emption from blocking. A held reset request driven through thirteen transfers reaches the stack limit and the sticky overflow.

// File: rtl/pvic_pkg.sv
package pvic_pkg;
  localparam int NSRC     = 12;
  localparam int LVL_W    = 4;
  localparam int IDLE_LVL = NSRC;

  // rank indices
  localparam int SRC_RST  = 0;
  localparam int SRC_PWD  = 1;
  localparam int SRC_EXT2 = 2;
  localparam int SRC_LV1  = 3;
  localparam int SRC_LV0  = 4;
  localparam int SRC_S0TX = 5;
  localparam int SRC_S0RX = 6;
  localparam int SRC_EDG  = 7;
  localparam int SRC_DMA  = 8;
  localparam int SRC_P1TX = 9;
  localparam int SRC_P1RX = 10;
  localparam int SRC_TMR  = 11;

  // handler address for a rank
  function automatic logic [15:0] vec_of(input logic [LVL_W-1:0] idx);
    logic [LVL_W-1:0] k;
    k = idx - 4'd1;
    case (idx)
      4'd0:    return 16'h0000;
      4'd1:    return 16'h002C;
      default: return {10'd0, k, 2'b00};
    endcase
  endfunction
endpackage

// File: rtl/pvic_pending.sv
module pvic_pending #(
  parameter int N = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw,
  input  logic [N-1:0] edge_mode,
  input  logic [N-1:0] set_vec,
  input  logic [N-1:0] clr_vec,
  output logic [N-1:0] pend
);
  for (genvar i = 0; i < N; i++) begin : g_src
    logic prev_q, latch_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev_q  <= 1'b0;
        latch_q <= 1'b0;
      end else begin
        prev_q <= raw[i];
        if (clr_vec[i])
          latch_q <= 1'b0;
        else if (set_vec[i] || (raw[i] && !prev_q))
          latch_q <= 1'b1;
      end
    end
    assign pend[i] = edge_mode[i] ? latch_q : raw[i];
  end
endmodule

// File: rtl/pvic_arbiter.sv
module pvic_arbiter
  import pvic_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic [N-1:0]     pend,
  input  logic [N-3:0]     mask,
  input  logic             gie,
  input  logic             blk,
  input  logic             nest_en,
  input  logic [LVL_W-1:0] cur_lvl,
  output logic             valid,
  output logic [LVL_W-1:0] win,
  output logic [15:0]      vector
);
  logic [N-1:0] elig;
  logic         any;
  logic         nest_ok;

  always_comb begin
    elig = pend & {mask, 2'b11} & {{(N-1){gie & ~blk}}, 1'b1};
    any  = 1'b0;
    win  = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (elig[i]) begin
        win = LVL_W'(i);
        any = 1'b1;
      end
    end
    if (win == '0)
      nest_ok = 1'b1;
    else if (nest_en)
      nest_ok = (win < cur_lvl);
    else
      nest_ok = (cur_lvl == LVL_W'(IDLE_LVL));
    valid  = any & nest_ok;
    vector = vec_of(win);
  end
endmodule

// File: rtl/pvic_nest.sv
module pvic_nest
  import pvic_pkg::*;
#(
  parameter int DEPTH = 12,
  localparam int DW   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic [LVL_W-1:0] new_lvl,
  output logic [LVL_W-1:0] cur_lvl,
  output logic [DW-1:0]    depth,
  output logic             ovf
);
  logic [LVL_W-1:0] stk [DEPTH];

  always_ff @(posedge clk) begin
    if (push && depth != DW'(DEPTH))
      stk[depth] <= cur_lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_lvl <= LVL_W'(IDLE_LVL);
      depth   <= '0;
      ovf     <= 1'b0;
    end else if (push) begin
      cur_lvl <= new_lvl;
      if (depth == DW'(DEPTH))
        ovf <= 1'b1;
      else
        depth <= depth + 1'b1;
    end else if (pop && depth != '0) begin
      cur_lvl <= stk[depth - 1'b1];
      depth   <= depth - 1'b1;
    end
  end
endmodule

// File: rtl/pvic_top.sv
module pvic_top
  import pvic_pkg::*;
#(
  parameter int VEC_W     = 16,
  parameter int STK_DEPTH = 12,
  localparam int DW       = $clog2(STK_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src_reset_i,
  input  logic             src_pwd_i,
  input  logic [2:0]       ext_i,
  input  logic [1:0]       lvl_i,
  input  logic             edge_i,
  input  logic             s0_tx_i,
  input  logic             s0_rx_i,
  input  logic             s1_tx_i,
  input  logic             s1_rx_i,
  input  logic             dma_i,
  input  logic             timer_i,
  input  logic             mask_we_i,
  input  logic [NSRC-3:0]  mask_wdata_i,
  input  logic             ctrl_we_i,
  input  logic [4:0]       ctrl_wdata_i,
  input  logic             fc_we_i,
  input  logic [1:0]       fc_wdata_i,
  input  logic             gie_set_i,
  input  logic             gie_clr_i,
  output logic             irq_valid_o,
  output logic [VEC_W-1:0] irq_vector_o,
  input  logic             irq_ready_i,
  input  logic             rti_i,
  output logic [LVL_W-1:0] active_lvl_o,
  output logic [DW-1:0]    depth_o,
  output logic             ovf_o
);
  logic [NSRC-3:0]  mask_q;
  logic [4:0]       ctrl_q;
  logic             gie_q, blk_q;
  logic [NSRC-1:0]  raw, edge_mode, set_vec, clr_vec, ack_vec, pend;
  logic [LVL_W-1:0] win;
  logic [15:0]      vec16;
  logic             hs, s1_ext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      ctrl_q <= '0;
      gie_q  <= 1'b1;
      blk_q  <= 1'b0;
    end else begin
      blk_q <= mask_we_i;
      if (mask_we_i) mask_q <= mask_wdata_i;
      if (ctrl_we_i) ctrl_q <= ctrl_wdata_i;
      if (gie_clr_i)      gie_q <= 1'b0;
      else if (gie_set_i) gie_q <= 1'b1;
    end
  end

  assign s1_ext = ctrl_q[4];

  always_comb begin
    raw       = '0;
    edge_mode = '1;
    raw[SRC_RST]  = src_reset_i;  edge_mode[SRC_RST] = 1'b0;
    raw[SRC_PWD]  = src_pwd_i;
    raw[SRC_EXT2] = ext_i[2];     edge_mode[SRC_EXT2] = ctrl_q[2];
    raw[SRC_LV1]  = lvl_i[1];     edge_mode[SRC_LV1]  = 1'b0;
    raw[SRC_LV0]  = lvl_i[0];     edge_mode[SRC_LV0]  = 1'b0;
    raw[SRC_S0TX] = s0_tx_i;
    raw[SRC_S0RX] = s0_rx_i;
    raw[SRC_EDG]  = edge_i;
    raw[SRC_DMA]  = dma_i;
    raw[SRC_P1TX] = s1_ext ? ext_i[1] : s1_tx_i;
    raw[SRC_P1RX] = s1_ext ? ext_i[0] : s1_rx_i;
    raw[SRC_TMR]  = timer_i;
    if (s1_ext) begin
      edge_mode[SRC_P1TX] = ctrl_q[1];
      edge_mode[SRC_P1RX] = ctrl_q[0];
    end
  end

  assign hs      = irq_valid_o & irq_ready_i;
  assign ack_vec = hs ? (NSRC'(1) << win) : '0;

  always_comb begin
    set_vec = '0;
    clr_vec = ack_vec;
    set_vec[SRC_EDG] = fc_we_i & fc_wdata_i[0];
    clr_vec[SRC_EDG] = ack_vec[SRC_EDG] | (fc_we_i & fc_wdata_i[1]);
  end

  pvic_pending #(.N(NSRC)) u_pend (
    .clk(clk), .rst_n(rst_n), .raw(raw), .edge_mode(edge_mode),
    .set_vec(set_vec), .clr_vec(clr_vec), .pend(pend)
  );

  pvic_arbiter #(.N(NSRC)) u_arb (
    .pend(pend), .mask(mask_q), .gie(gie_q), .blk(blk_q),
    .nest_en(ctrl_q[3]), .cur_lvl(active_lvl_o),
    .valid(irq_valid_o), .win(win), .vector(vec16)
  );

  pvic_nest #(.DEPTH(STK_DEPTH)) u_nest (
    .clk(clk), .rst_n(rst_n), .push(hs), .pop(rti_i), .new_lvl(win),
    .cur_lvl(active_lvl_o), .depth(depth_o), .ovf(ovf_o)
  );

  assign irq_vector_o = VEC_W'(vec16);
endmodule

// File: rtl/pvic_checks.sv
module pvic_checks
  import pvic_pkg::*;
#(
  parameter int VEC_W     = 16,
  parameter int STK_DEPTH = 12,
  localparam int DW       = $clog2(STK_DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mask_we_i,
  input logic             gie_clr_i,
  input logic             irq_valid_o,
  input logic             irq_ready_i,
  input logic [VEC_W-1:0] irq_vector_o,
  input logic             rti_i,
  input logic [LVL_W-1:0] active_lvl_o,
  input logic [DW-1:0]    depth_o,
  input logic             ovf_o
);
  logic [LVL_W-1:0] vlvl;
  logic             hs;

  always_comb begin
    if (irq_vector_o == '0)
      vlvl = '0;
    else if (irq_vector_o == VEC_W'(16'h002C))
      vlvl = 4'd1;
    else
      vlvl = LVL_W'((irq_vector_o >> 2) + 1'b1);
  end
  assign hs = irq_valid_o & irq_ready_i;

  p_blackout_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we_i |=> (!irq_valid_o || irq_vector_o == '0));

  p_gie_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    gie_clr_i |=> (!irq_valid_o || irq_vector_o == '0));

  p_rank_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid_o |-> (vlvl < active_lvl_o || irq_vector_o == '0));

  p_push_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && depth_o < DW'(STK_DEPTH)) |=> depth_o == $past(depth_o) + 1'b1);

  p_pop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rti_i && !hs && depth_o != '0) |=> depth_o == $past(depth_o) - 1'b1);

  p_full_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && depth_o == DW'(STK_DEPTH)) |=> (ovf_o && depth_o == DW'(STK_DEPTH)));

  p_no_overflow_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |=> ovf_o);

  p_depth_bound_r12: assert property (@(posedge clk) disable iff (!rst_n)
    depth_o <= DW'(STK_DEPTH));
endmodule

bind pvic_top pvic_checks #(.VEC_W(VEC_W), .STK_DEPTH(STK_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .mask_we_i(mask_we_i), .gie_clr_i(gie_clr_i),
  .irq_valid_o(irq_valid_o), .irq_ready_i(irq_ready_i),
  .irq_vector_o(irq_vector_o), .rti_i(rti_i), .active_lvl_o(active_lvl_o),
  .depth_o(depth_o), .ovf_o(ovf_o)
);

// File: tb/tb_pvic_top.sv
module tb_pvic_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic src_reset_i = 0, src_pwd_i = 0, edge_i = 0;
  logic [2:0] ext_i = '0;
  logic [1:0] lvl_i = '0;
  logic s0_tx_i = 0, s0_rx_i = 0, s1_tx_i = 0, s1_rx_i = 0, dma_i = 0, timer_i = 0;
  logic mask_we_i = 0, ctrl_we_i = 0, fc_we_i = 0, gie_set_i = 0, gie_clr_i = 0;
  logic [9:0] mask_wdata_i = '0;
  logic [4:0] ctrl_wdata_i = '0;
  logic [1:0] fc_wdata_i = '0;
  logic irq_ready_i = 0, rti_i = 0;
  logic irq_valid_o, ovf_o;
  logic [15:0] irq_vector_o;
  logic [3:0] active_lvl_o, depth_o;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pvic_top dut (
    .clk(clk), .rst_n(rst_n), .src_reset_i(src_reset_i), .src_pwd_i(src_pwd_i),
    .ext_i(ext_i), .lvl_i(lvl_i), .edge_i(edge_i), .s0_tx_i(s0_tx_i),
    .s0_rx_i(s0_rx_i), .s1_tx_i(s1_tx_i), .s1_rx_i(s1_rx_i), .dma_i(dma_i),
    .timer_i(timer_i), .mask_we_i(mask_we_i), .mask_wdata_i(mask_wdata_i),
    .ctrl_we_i(ctrl_we_i), .ctrl_wdata_i(ctrl_wdata_i), .fc_we_i(fc_we_i),
    .fc_wdata_i(fc_wdata_i), .gie_set_i(gie_set_i), .gie_clr_i(gie_clr_i),
    .irq_valid_o(irq_valid_o), .irq_vector_o(irq_vector_o),
    .irq_ready_i(irq_ready_i), .rti_i(rti_i), .active_lvl_o(active_lvl_o),
    .depth_o(depth_o), .ovf_o(ovf_o)
  );

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic offer(input string req, input logic [15:0] v);
    chk(req, {31'd0, irq_valid_o}, 32'd1);
    chk(req, {16'd0, irq_vector_o}, {16'd0, v});
  endtask

  task automatic wr_mask(input logic [9:0] v);
    mask_we_i = 1; mask_wdata_i = v; step(); mask_we_i = 0;
  endtask
  task automatic wr_ctrl(input logic [4:0] v);
    ctrl_we_i = 1; ctrl_wdata_i = v; step(); ctrl_we_i = 0;
  endtask
  task automatic wr_fc(input logic [1:0] v);
    fc_we_i = 1; fc_wdata_i = v; step(); fc_we_i = 0;
  endtask
  task automatic ack();
    irq_ready_i = 1; step(); irq_ready_i = 0;
  endtask
  task automatic ret();
    rti_i = 1; step(); rti_i = 0;
  endtask

  task automatic t_reset();
    rst_n = 0; repeat (3) step(); rst_n = 1; step();
    chk("R13 valid", {31'd0, irq_valid_o}, 0);
    chk("R13 depth", {28'd0, depth_o}, 0);
    chk("R13 ovf", {31'd0, ovf_o}, 0);
    chk("R13 idle", {28'd0, active_lvl_o}, 12);
    wr_mask(10'h3FF); step();
  endtask

  task automatic t_prio();
    lvl_i[0] = 1; timer_i = 1; step(); timer_i = 0;
    offer("R1 level0 over timer", 16'h000C);
    ack();
    chk("R9 active", {28'd0, active_lvl_o}, 4);
    chk("R9 nest off blocks", {31'd0, irq_valid_o}, 0);
    ret();
    offer("R7 level re-offered", 16'h000C);
    lvl_i[0] = 0; step();
    offer("R1 timer", 16'h0028);
    ack(); ret();
    chk("R8 timer latch cleared", {31'd0, irq_valid_o}, 0);
    chk("R11 depth", {28'd0, depth_o}, 0);
  endtask

  task automatic t_mask();
    wr_mask(10'h1FF); step();
    timer_i = 1; step(); timer_i = 0; step();
    chk("R2 masked timer", {31'd0, irq_valid_o}, 0);
    pwd_pulse();
    offer("R3 pwd unmaskable", 16'h002C);
    ack(); ret();
    chk("R2 still masked", {31'd0, irq_valid_o}, 0);
    wr_mask(10'h3FF);
    chk("R4 blackout", {31'd0, irq_valid_o}, 0);
    step();
    offer("R4 after blackout", 16'h0028);
    ack(); ret();
  endtask

  task automatic pwd_pulse();
    src_pwd_i = 1; step(); src_pwd_i = 0; step();
  endtask

  task automatic t_edge();
    ext_i[2] = 1; step();
    offer("R5 ext2 level", 16'h0004);
    ext_i[2] = 0; step();
    chk("R5 ext2 level drop", {31'd0, irq_valid_o}, 0);
    wr_ctrl(5'b00100); step();
    ext_i[2] = 1; step(); ext_i[2] = 0; step();
    offer("R5 ext2 edge latched", 16'h0004);
    ack(); ret();
    wr_ctrl(5'b10001); step();
    s1_rx_i = 1; step(); s1_rx_i = 0; step();
    chk("R5 serial ignored", {31'd0, irq_valid_o}, 0);
    ext_i[0] = 1; step(); ext_i[0] = 0; step();
    offer("R5 ext0 at rank 10", 16'h0024);
    ack(); ret();
    wr_ctrl(5'b00000); step();
    chk("R5 idle", {31'd0, irq_valid_o}, 0);
  endtask

  task automatic t_force();
    wr_fc(2'b01);
    offer("R6 force", 16'h0018);
    wr_fc(2'b10);
    chk("R6 clear", {31'd0, irq_valid_o}, 0);
    wr_fc(2'b11);
    chk("R6 clear wins", {31'd0, irq_valid_o}, 0);
    edge_i = 1; step(); edge_i = 0; step();
    offer("R6 edge", 16'h0018);
    ack(); ret();
    chk("R8 edge latch cleared", {31'd0, irq_valid_o}, 0);
  endtask

  task automatic t_nest();
    wr_ctrl(5'b01000); step();
    timer_i = 1; step(); timer_i = 0;
    offer("R9 timer", 16'h0028);
    ack();
    chk("R9 active timer", {28'd0, active_lvl_o}, 11);
    dma_i = 1; step(); dma_i = 0;
    offer("R9 dma preempts", 16'h001C);
    ack();
    chk("R9 active dma", {28'd0, active_lvl_o}, 8);
    chk("R9 depth 2", {28'd0, depth_o}, 2);
    s1_tx_i = 1; step(); s1_tx_i = 0; step();
    chk("R9 lower blocked", {31'd0, irq_valid_o}, 0);
    ret();
    chk("R11 restore", {28'd0, active_lvl_o}, 11);
    chk("R11 depth 1", {28'd0, depth_o}, 1);
    offer("R9 s1tx preempts timer", 16'h0020);
    ack(); ret(); ret();
    chk("R11 idle", {28'd0, active_lvl_o}, 12);
    chk("R11 empty", {28'd0, depth_o}, 0);
    ret();
    chk("R11 pop empty ignored", {28'd0, depth_o}, 0);
    chk("R11 pop empty idle", {28'd0, active_lvl_o}, 12);
  endtask

  task automatic t_gie();
    gie_clr_i = 1; step(); gie_clr_i = 0;
    pwd_pulse();
    chk("R10 pwd gated", {31'd0, irq_valid_o}, 0);
    gie_set_i = 1; step(); gie_set_i = 0;
    offer("R10 pwd after enable", 16'h002C);
    ack(); ret();
    gie_clr_i = 1; gie_set_i = 1; step(); gie_clr_i = 0; gie_set_i = 0;
    timer_i = 1; step(); timer_i = 0; step();
    chk("R10 clear wins", {31'd0, irq_valid_o}, 0);
    src_reset_i = 1; step();
    offer("R10 reset ignores gie", 16'h0000);
    src_reset_i = 0;
    gie_set_i = 1; step(); gie_set_i = 0;
    offer("R10 timer after enable", 16'h0028);
    step(); step();
    chk("R13 no transfer w/o ready", {28'd0, depth_o}, 0);
    ack(); ret();
  endtask

  task automatic t_stack();
    src_reset_i = 1; irq_ready_i = 1;
    repeat (12) step();
    chk("R12 depth full", {28'd0, depth_o}, 12);
    chk("R12 no ovf yet", {31'd0, ovf_o}, 0);
    step();
    chk("R12 ovf", {31'd0, ovf_o}, 1);
    chk("R12 depth held", {28'd0, depth_o}, 12);
    src_reset_i = 0; irq_ready_i = 0; step();
    repeat (12) ret();
    chk("R12 drained", {28'd0, depth_o}, 0);
    chk("R12 ovf sticky", {31'd0, ovf_o}, 1);
    chk("R12 idle", {28'd0, active_lvl_o}, 12);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_prio();
    t_mask();
    t_edge();
    t_force();
    t_nest();
    t_gie();
    t_stack();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule